// File: doc/BRIEF.md
# Crystal clock-loss watchdog

This block monitors a slow 32 kHz crystal clock from a separate, always-running monitor clock domain. Crystal rising edges are brought into the monitor domain through a flop synchronizer. Each detected edge reloads a down-counter with a programmed 8-bit timeout. If the counter runs out before the next crystal edge arrives, the crystal is declared dead.

A dead crystal sets a sticky interrupt status bit. The interrupt line is raised when both the watchdog and its interrupt are enabled. If automatic fail-over is enabled, the slow clock output also moves from the crystal to a backup clock input.

Software restores normal operation in two steps. It raises the watchdog reset control and then drops it again. This clears the dead state and reselects the crystal. The interrupt status is cleared separately, by a write-one-to-clear pulse.

Top module: `xtal_loss_wdt`

## Requirements
- R1: After the synchronous reset, `xtal_dead`, `irq_status`, `irq` and `backup_sel` are all 0.
- R2: With the watchdog enabled, a timeout of T (1..255) and no crystal edge, `xtal_dead` is still 0 after T-1 monitor clock edges and is 1 after the T-th edge. The count starts with the first edge at which the enable is sampled high.
- R3: While enabled, crystal rising edges spaced no more than T-3 monitor cycles apart never cause `xtal_dead`. Each detected edge reloads the counter to T.
- R4: While `wdt_en` is 0, `xtal_dead` stays 0 and `backup_sel` stays 0, so the crystal remains selected.
- R5: `irq_status` sets one cycle after `xtal_dead` rises. It remains set even when the crystal resumes or the watchdog is reset. It is cleared only by a one-cycle pulse on `irq_clr`.
- R6: `irq` follows `irq_status`, qualified by `wdt_en` and `irq_en`, one cycle later. With `irq_en` at 0, `irq` stays 0.
- R7: When `auto_backup_en` is 1, `backup_sel` becomes 1 one cycle after `xtal_dead` rises, and `slow_clk` then carries `backup_clk`. When `auto_backup_en` is 0, `backup_sel` stays 0 and `slow_clk` carries `xtal_clk`.
- R8: While `wdt_rst` is 1, `xtal_dead` and `backup_sel` are cleared and the counter holds at T. After `wdt_rst` returns to 0, counting restarts from T.
- R9: A timeout value of 0 acts as 1.
- R10: Once set, `xtal_dead` holds, even if crystal edges return, until `wdt_rst` is raised or `wdt_en` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running monitor clock |
| rst | input | 1 | Synchronous active-high reset |
| xtal_clk | input | 1 | Monitored crystal clock (asynchronous) |
| backup_clk | input | 1 | Backup slow clock |
| wdt_en | input | 1 | Watchdog enable |
| wdt_rst | input | 1 | Watchdog reset control, level |
| wdt_timeout | input | 8 | Timeout in monitor clock cycles |
| auto_backup_en | input | 1 | Fail over to the backup clock on expiry |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Write-one-to-clear pulse for the status bit |
| xtal_dead | output | 1 | Crystal declared dead |
| irq_status | output | 1 | Sticky crystal-dead status |
| irq | output | 1 | Interrupt request |
| backup_sel | output | 1 | 1 when the backup clock drives the slow clock |
| slow_clk | output | 1 | Selected slow clock |

## Verification
The counter is tried with a crystal held still, to find the exact expiry cycle at several timeouts, including 0 and 255. It is also tried with a crystal toggling at random periods below the timeout, which shows that edges reload the counter. A stop of that same crystal shows expiry after activity.

Resuming the crystal after expiry separates sticky state from live state. Toggling the clear, reset and enable controls separates the status path from the dead and select paths. Runs with fail-over on and off show whether the mux follows the dead flag or the configuration.

// File: rtl/xlw_pkg.sv
package xlw_pkg;
  localparam int XLW_TO_W = 8;
  localparam int XLW_SYNC_STAGES = 2;

  typedef enum logic {
    SRC_XTAL   = 1'b0,
    SRC_BACKUP = 1'b1
  } src_sel_e;
endpackage

// File: rtl/xlw_edge_sync.sv
module xlw_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= chain[STAGES-1];
  end

  assign rise = chain[STAGES-1] & ~last_q;

  // R3
  edge_single_chk: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/xlw_timeout_ctr.sv
module xlw_timeout_ctr #(
  parameter int TO_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            wdt_rst,
  input  logic [TO_W-1:0] timeout,
  input  logic            edge_seen,
  output logic            dead,
  output logic            expire
);
  localparam logic [TO_W-1:0] ONE = TO_W'(1);

  logic [TO_W-1:0] cnt_q;
  logic [TO_W-1:0] reload;

  assign reload = (timeout == '0) ? ONE : timeout;

  always_ff @(posedge clk) begin
    expire <= 1'b0;
    if (rst || !en || wdt_rst) begin
      cnt_q <= reload;
      dead  <= 1'b0;
    end else if (dead) begin
      cnt_q <= cnt_q;
    end else if (edge_seen) begin
      cnt_q <= reload;
    end else if (cnt_q <= ONE) begin
      cnt_q  <= '0;
      dead   <= 1'b1;
      expire <= 1'b1;
    end else begin
      cnt_q <= cnt_q - ONE;
    end
  end

  // R4
  disabled_never_dead_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !dead);
  // R10
  dead_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (dead && en && !wdt_rst) |=> dead);
  // R2
  dead_after_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dead) |-> ($past(cnt_q) <= ONE));
  // R8
  wdt_rst_clears_chk: assert property (@(posedge clk) disable iff (rst)
    wdt_rst |=> !dead);
endmodule

// File: rtl/xlw_irq_ctl.sv
module xlw_irq_ctl (
  input  logic clk,
  input  logic rst,
  input  logic expire,
  input  logic clr,
  input  logic en,
  input  logic irq_en,
  output logic status,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      status <= 1'b0;
      irq    <= 1'b0;
    end else begin
      if (expire)   status <= 1'b1;
      else if (clr) status <= 1'b0;
      irq <= status & en & irq_en;
    end
  end

  // R5
  status_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (status && !clr) |=> status);
  // R6
  irq_gated_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_en |=> !irq);
endmodule

// File: rtl/xlw_src_select.sv
module xlw_src_select
  import xlw_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic wdt_rst,
  input  logic dead,
  input  logic auto_backup,
  input  logic xtal_clk,
  input  logic backup_clk,
  output logic backup_sel,
  output logic slow_clk
);
  src_sel_e sel_q;

  always_ff @(posedge clk) begin
    if (rst || !en || wdt_rst) sel_q <= SRC_XTAL;
    else if (dead && auto_backup) sel_q <= SRC_BACKUP;
  end

  assign backup_sel = (sel_q == SRC_BACKUP);
  assign slow_clk   = (sel_q == SRC_BACKUP) ? backup_clk : xtal_clk;

  // R7
  backup_needs_dead_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(backup_sel) |-> $past(dead) && $past(auto_backup));
endmodule

// File: rtl/xtal_loss_wdt.sv
module xtal_loss_wdt
  import xlw_pkg::*;
#(
  parameter int TO_W        = XLW_TO_W,
  parameter int SYNC_STAGES = XLW_SYNC_STAGES
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            xtal_clk,
  input  logic            backup_clk,
  input  logic            wdt_en,
  input  logic            wdt_rst,
  input  logic [TO_W-1:0] wdt_timeout,
  input  logic            auto_backup_en,
  input  logic            irq_en,
  input  logic            irq_clr,
  output logic            xtal_dead,
  output logic            irq_status,
  output logic            irq,
  output logic            backup_sel,
  output logic            slow_clk
);
  logic xtal_rise;
  logic expire;

  xlw_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(xtal_clk), .rise(xtal_rise)
  );

  xlw_timeout_ctr #(.TO_W(TO_W)) u_ctr (
    .clk(clk), .rst(rst), .en(wdt_en), .wdt_rst(wdt_rst),
    .timeout(wdt_timeout), .edge_seen(xtal_rise),
    .dead(xtal_dead), .expire(expire)
  );

  xlw_irq_ctl u_irq (
    .clk(clk), .rst(rst), .expire(expire), .clr(irq_clr),
    .en(wdt_en), .irq_en(irq_en), .status(irq_status), .irq(irq)
  );

  xlw_src_select u_sel (
    .clk(clk), .rst(rst), .en(wdt_en), .wdt_rst(wdt_rst),
    .dead(xtal_dead), .auto_backup(auto_backup_en),
    .xtal_clk(xtal_clk), .backup_clk(backup_clk),
    .backup_sel(backup_sel), .slow_clk(slow_clk)
  );

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!xtal_dead && !irq_status && !irq && !backup_sel));
endmodule

// File: tb/test_xtal_loss_wdt.sv
module test_xtal_loss_wdt;
  logic clk = 0;
  logic rst = 1;
  logic xtal = 0, bkp = 0;
  logic en = 0, wrst = 0, aen = 0, ien = 0, clr = 0;
  logic [7:0] to = 8'd10;
  logic dead, st, irq, bsel, sclk;
  int checks = 0, errors = 0;
  int phase = 0;
  int per = 0;

  always #2.5 clk = ~clk;

  xtal_loss_wdt i_xtal_loss_wdt (
    .clk(clk), .rst(rst), .xtal_clk(xtal), .backup_clk(bkp),
    .wdt_en(en), .wdt_rst(wrst), .wdt_timeout(to), .auto_backup_en(aen),
    .irq_en(ien), .irq_clr(clr), .xtal_dead(dead), .irq_status(st),
    .irq(irq), .backup_sel(bsel), .slow_clk(sclk)
  );

  function automatic int eff_to(input logic [7:0] t);
    return (t == 8'd0) ? 1 : int'(t);
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (per > 0) begin
        phase++;
        if (phase >= per) begin
          phase = 0;
          xtal = ~xtal;
        end
      end
    end
  endtask

  task automatic stop_xtal();
    per = 0;
    xtal = 0;
  endtask

  task automatic restart();
    en = 0;
    step(4);
  endtask

  task automatic expiry_exact(input logic [7:0] t, input string req);
    stop_xtal();
    restart();
    to = t;
    step(1);
    en = 1;
    if (eff_to(t) > 1) begin
      step(eff_to(t) - 1);
      chk(req, dead, 1'b0);
    end
    step(1);
    chk(req, dead, 1'b1);
  endtask

  initial begin
    step(3);
    rst = 0;
    step(1);
    chk("R1 dead", dead, 1'b0);
    chk("R1 status", st, 1'b0);
    chk("R1 irq", irq, 1'b0);
    chk("R1 sel", bsel, 1'b0);

    aen = 1;
    ien = 1;
    expiry_exact(8'd10, "R2 t=10");
    step(1);
    chk("R5 status set", st, 1'b1);
    chk("R7 sel set", bsel, 1'b1);
    bkp = 1;
    xtal = 0;
    #1;
    chk("R7 mux backup", sclk, 1'b1);
    bkp = 0;
    step(1);
    chk("R6 irq", irq, 1'b1);

    per = 2;
    step(30);
    chk("R10 dead held", dead, 1'b1);
    chk("R5 status held", st, 1'b1);

    clr = 1;
    step(1);
    clr = 0;
    chk("R5 cleared", st, 1'b0);
    step(1);
    chk("R6 irq drops", irq, 1'b0);

    stop_xtal();
    wrst = 1;
    step(1);
    chk("R8 dead cleared", dead, 1'b0);
    step(1);
    chk("R8 sel cleared", bsel, 1'b0);
    step(20);
    chk("R8 held", dead, 1'b0);
    wrst = 0;
    step(9);
    chk("R8 restart", dead, 1'b0);
    step(1);
    chk("R8 restart", dead, 1'b1);

    expiry_exact(8'd0, "R9 t=0");
    expiry_exact(8'd1, "R2 t=1");
    expiry_exact(8'd255, "R2 t=255");

    ien = 0;
    clr = 1;
    step(1);
    clr = 0;
    aen = 0;
    expiry_exact(8'd5, "R2 t=5");
    step(3);
    chk("R6 irq masked", irq, 1'b0);
    chk("R7 no fail-over", bsel, 1'b0);
    xtal = 1;
    bkp = 0;
    #1;
    chk("R7 mux xtal", sclk, 1'b1);
    xtal = 0;

    en = 0;
    step(300);
    chk("R4 disabled dead", dead, 1'b0);
    chk("R4 disabled sel", bsel, 1'b0);

    aen = 1;
    for (int k = 0; k < 20; k++) begin
      int t;
      t = 20 + int'($urandom(k + 7) % 236);
      restart();
      to = 8'(t);
      per = 1 + int'($urandom() % ((t - 4) / 2));
      phase = 0;
      step(1);
      en = 1;
      step(3 * t);
      chk("R3 alive", dead, 1'b0);
      stop_xtal();
      step(t + 4);
      chk("R2 stopped", dead, 1'b1);
      chk("R7 random sel", bsel, 1'b1);
      en = 0;
      step(2);
      chk("R4 drop", dead, 1'b0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule